// File: doc/BRIEF.md
# SPI Serial EEPROM Word Controller

This block connects a host to a serial EEPROM that speaks SPI mode 0 with an active-low chip select. The host asks for a run of 16-bit words, either to read or to write, by giving a word offset and a word count. The block then runs the full command sequence on the serial pins. Before every command it polls the device status until the device is idle. For writes, it sets the write latch and splits the run into page-sized segments. It turns word offsets into byte addresses and swaps the two bytes of each word on the wire.

The device stores bytes, and the low byte of a word sits at the lower byte address. Some small parts take an 8-bit address field. On those parts the ninth address bit travels inside the command opcode.

Write data is taken from `wr_data`. A pulse on `wr_pop` tells the host that a word was taken and the next one should be presented. Read words come out on `rd_data`, and each is marked by a one-cycle `rd_valid`. The end of every request is marked by a one-cycle `done`, with `err` raised in the same cycle when the request failed.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Before each command segment, the block opens a frame and sends opcode 0x05, then shifts in 8 status bits. While status bit 0 (busy) reads 1, it closes the frame, holds chip select high for a gap and polls again. When bit 0 reads 0, it goes on with the command.
- R2: If POLL_TRIES status frames in a row report busy, the request ends with `err` and `done`. No write command is sent, and the device contents stay unchanged.
- R3: The address field is the byte address, equal to twice the word offset. It is sent MSB first, right after the opcode, and is ADDR_BITS wide, using the low ADDR_BITS bits of the byte address.
- R4: With ADDR_BITS = 8, the read opcode is 0x03 and the write opcode is 0x02. When the segment's word offset is 128 or more, 0x08 is ORed into either opcode, giving 0x0B or 0x0A.
- R5: A read sends one opcode and one address, then shifts in one 16-bit word per requested word. The first byte received is the low byte of `rd_data`. Each word is marked by one `rd_valid` pulse.
- R6: A written word goes out low byte first, each byte MSB first. `wr_pop` pulses once per word taken, and only while chip select is low.
- R7: Each write segment is built from these frames:
  - a status poll;
  - a one-byte frame with opcode 0x06, closed by chip select going high;
  - a new frame carrying the write opcode, the address and the data words.
- R8: A write segment closes as soon as the next byte address is a multiple of PAGE_BYTES. The remaining words then start a new segment, beginning with a fresh status poll.
- R9: A request is rejected with `err` and `done`, and without lowering chip select, when any of these holds:
  - the count is 0;
  - the offset is not below the device word count;
  - the count exceeds the words left from the offset.
- R10: The serial pins follow SPI mode 0:
  - while chip select is high, including from reset, the clock is low;
  - MOSI holds steady while the clock is high;
  - MISO is sampled on the rising clock edge.
- R11: A request is taken only while `busy` is low. `busy` stays high from acceptance until the `done` pulse, and `done` lasts one cycle. Chip select is high whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a request (sampled while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 16 | First word offset |
| req_count | input | 17 | Number of words |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request failed (valid with `done`) |
| wr_data | input | 16 | Next word to write |
| wr_pop | output | 1 | `wr_data` was taken; present the next word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| rd_data | output | 16 | Word read from the device |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with the following parameters:
- ADDR_BITS = 8;
- PAGE_BYTES = 16;
- HALF_CLKS = 2;
- POLL_TRIES = 4;
- a short gap.

With 8-bit addresses, the 512-byte device model puts offsets of 128 and above behind the opcode-carried ninth bit. A 20-word write crosses that line and two 16-byte page boundaries in one request. A model that wraps writes inside a page turns a missed split into corrupted data, which the reads then catch. The model reports busy for two polls after each write, and can be forced permanently busy. With only four tries, both the retry path and the timeout path are reached within a few hundred cycles.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_A8    = 8'h08;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_GAP,
        ST_POLL_OP,
        ST_POLL_IN,
        ST_WREN,
        ST_CMD,
        ST_ADDR,
        ST_DATA
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } shift_phase_e;

    typedef struct packed {
        logic        write;
        logic [15:0] offset;
        logic [16:0] count;
    } host_req_t;

    function automatic logic [15:0] swap16(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/spi_eeprom_shifter.sv
module spi_eeprom_shifter
    import spi_eeprom_pkg::*;
#(
    parameter int HALF_CLKS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [4:0]  nbits,
    input  logic [15:0] dout,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        done,
    output logic [15:0] din
);
    localparam int HW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CLKS - 1);

    shift_phase_e phase;
    logic [HW-1:0] cnt;
    logic [15:0]   shreg;
    logic [4:0]    left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            shreg <= '0;
            left  <= '0;
            sck   <= 1'b0;
            done  <= 1'b0;
            din   <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        shreg <= dout << (5'd16 - nbits);
                        left  <= nbits;
                        cnt   <= '0;
                        din   <= '0;
                        phase <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (cnt == HALF_LAST) begin
                        cnt   <= '0;
                        sck   <= 1'b1;
                        din   <= {din[14:0], miso};
                        phase <= PH_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == HALF_LAST) begin
                        cnt   <= '0;
                        sck   <= 1'b0;
                        shreg <= shreg << 1;
                        left  <= left - 1'b1;
                        if (left == 5'd1) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            phase <= PH_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign mosi = (phase != PH_IDLE) ? shreg[15] : 1'b0;

endmodule

// File: rtl/spi_eeprom_gap_timer.sv
module spi_eeprom_gap_timer #(
    parameter int GAP_CLKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int GW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;

    logic          run;
    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= GW'(GAP_CLKS - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

endmodule

// File: rtl/spi_eeprom_range_chk.sv
module spi_eeprom_range_chk #(
    parameter int WORDS = 256
) (
    input  logic [15:0] offset,
    input  logic [16:0] count,
    output logic        ok
);
    logic [17:0] off_x;
    logic [17:0] room;

    always_comb begin
        off_x = {2'b00, offset};
        room  = 18'(WORDS) - off_x;
        ok    = (off_x < 18'(WORDS)) && (count != '0) && ({1'b0, count} <= room);
    end

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_BITS  = 8,
    parameter int PAGE_BYTES = 32,
    parameter int HALF_CLKS  = 4,
    parameter int POLL_TRIES = 64,
    parameter int GAP_CLKS   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_offset,
    input  logic [16:0] req_count,
    output logic        busy,
    output logic        done,
    output logic        err,
    input  logic [15:0] wr_data,
    output logic        wr_pop,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int OFF_W      = (ADDR_BITS == 8) ? 8 : 15;
    localparam int WORDS      = 1 << OFF_W;
    localparam int PAGE_WORDS = (PAGE_BYTES >= 2) ? PAGE_BYTES / 2 : 1;
    localparam int TRY_W      = $clog2(POLL_TRIES + 1);
    localparam logic [OFF_W-1:0] PG_MASK = OFF_W'(PAGE_WORDS - 1);
    localparam logic [4:0] ADDR_NB = 5'(ADDR_BITS);

    seq_state_e st, gap_next;
    host_req_t  req_q;
    logic [OFF_W-1:0] off_q, off_nx;
    logic [16:0]      left_q;
    logic [TRY_W-1:0] tries_q;

    logic        sh_start_q, sh_done, gap_go_q, gap_done, range_ok;
    logic [4:0]  sh_nbits_q;
    logic [15:0] sh_dout_q, sh_din, addr_word;
    logic        a8, page_end;
    logic [7:0]  cmd_opc, launch_byte;

    logic cs_n_q, done_q, err_q, rd_valid_q, wr_pop_q;
    logic [15:0] rd_data_q;

    spi_eeprom_shifter #(.HALF_CLKS(HALF_CLKS)) shifter_i (
        .clk(clk), .rst(rst), .start(sh_start_q), .nbits(sh_nbits_q),
        .dout(sh_dout_q), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .done(sh_done), .din(sh_din)
    );

    spi_eeprom_gap_timer #(.GAP_CLKS(GAP_CLKS)) gap_i (
        .clk(clk), .rst(rst), .start(gap_go_q), .expired(gap_done)
    );

    spi_eeprom_range_chk #(.WORDS(WORDS)) range_i (
        .offset(req_q.offset), .count(req_q.count), .ok(range_ok)
    );

    generate
        if (ADDR_BITS == 8) begin : g_short_addr
            assign a8        = off_q[OFF_W-1];
            assign addr_word = 16'({off_q[OFF_W-2:0], 1'b0});
        end else begin : g_wide_addr
            assign a8        = 1'b0;
            assign addr_word = 16'({off_q, 1'b0});
        end
    endgenerate

    always_comb begin
        off_nx   = off_q + 1'b1;
        page_end = ((off_nx & PG_MASK) == '0);
        cmd_opc  = (req_q.write ? OPC_WRITE : OPC_READ) | (a8 ? OPC_A8 : 8'h00);
        case (gap_next)
            ST_POLL_OP: launch_byte = OPC_RDSR;
            ST_WREN:    launch_byte = OPC_WREN;
            default:    launch_byte = cmd_opc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            gap_next   <= ST_POLL_OP;
            req_q      <= '0;
            off_q      <= '0;
            left_q     <= '0;
            tries_q    <= '0;
            sh_start_q <= 1'b0;
            sh_nbits_q <= '0;
            sh_dout_q  <= '0;
            gap_go_q   <= 1'b0;
            cs_n_q     <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            wr_pop_q   <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            rd_valid_q <= 1'b0;
            wr_pop_q   <= 1'b0;
            sh_start_q <= 1'b0;
            gap_go_q   <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q <= '{write: req_write, offset: req_offset, count: req_count};
                        st    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!range_ok) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        off_q    <= req_q.offset[OFF_W-1:0];
                        left_q   <= req_q.count;
                        tries_q  <= TRY_W'(POLL_TRIES);
                        gap_next <= ST_POLL_OP;
                        gap_go_q <= 1'b1;
                        st       <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        cs_n_q     <= 1'b0;
                        sh_start_q <= 1'b1;
                        sh_nbits_q <= 5'd8;
                        sh_dout_q  <= {8'h00, launch_byte};
                        st         <= gap_next;
                    end
                end
                ST_POLL_OP: begin
                    if (sh_done) begin
                        sh_start_q <= 1'b1;
                        sh_nbits_q <= 5'd8;
                        sh_dout_q  <= '0;
                        st         <= ST_POLL_IN;
                    end
                end
                ST_POLL_IN: begin
                    if (sh_done) begin
                        cs_n_q <= 1'b1;
                        if (!sh_din[0]) begin
                            gap_next <= req_q.write ? ST_WREN : ST_CMD;
                            gap_go_q <= 1'b1;
                            st       <= ST_GAP;
                        end else if (tries_q == TRY_W'(1)) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            tries_q  <= tries_q - 1'b1;
                            gap_next <= ST_POLL_OP;
                            gap_go_q <= 1'b1;
                            st       <= ST_GAP;
                        end
                    end
                end
                ST_WREN: begin
                    if (sh_done) begin
                        cs_n_q   <= 1'b1;
                        gap_next <= ST_CMD;
                        gap_go_q <= 1'b1;
                        st       <= ST_GAP;
                    end
                end
                ST_CMD: begin
                    if (sh_done) begin
                        sh_start_q <= 1'b1;
                        sh_nbits_q <= ADDR_NB;
                        sh_dout_q  <= addr_word;
                        st         <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (sh_done) begin
                        sh_start_q <= 1'b1;
                        sh_nbits_q <= 5'd16;
                        sh_dout_q  <= req_q.write ? swap16(wr_data) : 16'h0000;
                        wr_pop_q   <= req_q.write;
                        st         <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (sh_done) begin
                        if (!req_q.write) begin
                            rd_valid_q <= 1'b1;
                            rd_data_q  <= swap16(sh_din);
                        end
                        left_q <= left_q - 1'b1;
                        off_q  <= off_nx;
                        if (left_q == 17'd1) begin
                            cs_n_q <= 1'b1;
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else if (req_q.write && page_end) begin
                            cs_n_q   <= 1'b1;
                            tries_q  <= TRY_W'(POLL_TRIES);
                            gap_next <= ST_POLL_OP;
                            gap_go_q <= 1'b1;
                            st       <= ST_GAP;
                        end else begin
                            sh_start_q <= 1'b1;
                            sh_nbits_q <= 5'd16;
                            sh_dout_q  <= req_q.write ? swap16(wr_data) : 16'h0000;
                            wr_pop_q   <= req_q.write;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign wr_pop   = wr_pop_q;
    assign spi_cs_n = cs_n_q;

endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi,
    input logic busy,
    input logic done,
    input logic err,
    input logic wr_pop
);
    AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck) else $error("clock high with chip select high"); // R10

    AST_MOSI_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)) else $error("mosi moved while clock high"); // R10

    AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done) else $error("err without done"); // R9

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R11

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n) else $error("chip select low while idle"); // R11

    AST_POP_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_pop |-> !spi_cs_n) else $error("word taken outside a frame"); // R6

endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .busy(busy), .done(done), .err(err), .wr_pop(wr_pop)
);

// File: tb/spi_eeprom_ctrl_tb_top.sv
module spi_eeprom_ctrl_tb_top;
    localparam int PAGE  = 16;
    localparam int TRIES = 4;
    localparam int NVEC  = 10;

    typedef struct packed {
        logic        exp_err;
        logic        wr;
        logic [15:0] off;
        logic [16:0] cnt;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 16'd5,   17'd3},
        '{1'b0, 1'b0, 16'd5,   17'd3},
        '{1'b0, 1'b1, 16'd120, 17'd20},
        '{1'b0, 1'b0, 16'd118, 17'd24},
        '{1'b1, 1'b0, 16'd0,   17'd0},
        '{1'b1, 1'b0, 16'd250, 17'd7},
        '{1'b0, 1'b0, 16'd250, 17'd6},
        '{1'b0, 1'b1, 16'd255, 17'd1},
        '{1'b1, 1'b1, 16'd300, 17'd1},
        '{1'b0, 1'b0, 16'd254, 17'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_offset = '0;
    logic [16:0] req_count = '0;
    logic busy, done, err, wr_pop, rd_valid;
    logic [15:0] rd_data, wr_data;
    logic spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    always #4 clk = ~clk;

    spi_eeprom_ctrl #(
        .ADDR_BITS(8), .PAGE_BYTES(PAGE), .HALF_CLKS(2),
        .POLL_TRIES(TRIES), .GAP_CLKS(3)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_count(req_count), .busy(busy),
        .done(done), .err(err), .wr_data(wr_data), .wr_pop(wr_pop),
        .rd_valid(rd_valid), .rd_data(rd_data), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [15:0] ipat(input int i);
        return 16'((i * 16'h0101) ^ 16'h5A3C);
    endfunction

    function automatic logic [15:0] wval(input int i, input int v);
        return 16'((i * 16'h0123) ^ (v * 16'h1111) ^ 16'hA55A);
    endfunction

    // ---------------- device model ----------------
    logic [7:0] mem [512];
    logic [15:0] shadow [256];
    int  bitcnt = 0, addr = 0, busy_polls = 0;
    int  stat_reads = 0, wseg = 0, wren_cnt = 0, frames = 0, last_addr = -1;
    logic [7:0] sh = '0, op = '0, last_op = '0;
    bit  wel = 0, wrote = 0, force_busy = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (prev_cs && !spi_cs_n) begin
            bitcnt = 0; wrote = 0; op = 8'h00; frames++;
        end
        if (!prev_cs && spi_cs_n) begin
            if (op == 8'h05 && bitcnt >= 16 && busy_polls > 0) busy_polls--;
            if (wrote) begin wseg++; busy_polls = 2; wel = 0; end
        end
        if (!spi_cs_n && !prev_sck && spi_sck) begin
            sh = {sh[6:0], spi_mosi};
            bitcnt++;
            if (bitcnt % 8 == 0) begin
                if (bitcnt == 8) begin
                    op = sh;
                    if (op == 8'h06) begin wel = 1; wren_cnt++; end
                    if (op == 8'h05) stat_reads++;
                    if ((op & 8'hF7) == 8'h02 || (op & 8'hF7) == 8'h03) last_op = op;
                end else if (bitcnt == 16 && ((op & 8'hF7) == 8'h02 || (op & 8'hF7) == 8'h03)) begin
                    addr = int'(op[3]) * 256 + int'(sh);
                    last_addr = addr;
                end else if (bitcnt > 16 && (op & 8'hF7) == 8'h02 && wel) begin
                    mem[(addr & ~(PAGE - 1)) | ((addr + bitcnt / 8 - 3) & (PAGE - 1))] = sh;
                    wrote = 1;
                end
            end
        end
        if (!spi_cs_n && prev_sck && !spi_sck) begin
            if (op == 8'h05 && bitcnt >= 8)
                spi_miso = (((bitcnt - 8) % 8) == 7) ? (force_busy || busy_polls > 0) : 1'b0;
            else if ((op & 8'hF7) == 8'h03 && bitcnt >= 16)
                spi_miso = mem[(addr + (bitcnt - 16) / 8) % 512][7 - (bitcnt - 16) % 8];
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    // ---------------- host side helpers ----------------
    int wr_idx = 0, wr_base = 0, cur_off = 0, cur_vec = 0;
    int rd_n = 0;
    logic [15:0] rd_buf [64];

    assign wr_data = wval(cur_off + (wr_idx - wr_base), cur_vec);

    always @(posedge clk) begin
        if (wr_pop) wr_idx <= wr_idx + 1;
        if (rd_valid) begin
            rd_buf[rd_n % 64] <= rd_data;
            rd_n <= rd_n + 1;
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input bit wr, input int off, input int cnt, input int v,
                           output bit got_err);
        while (busy) @(negedge clk);
        cur_off = off; cur_vec = v; wr_base = wr_idx;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_offset = 16'(off); req_count = 17'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got_err = err;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog expired: actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit e;
        for (int i = 0; i < 256; i++) begin
            shadow[i]      = ipat(i);
            mem[2 * i]     = ipat(i)[7:0];
            mem[2 * i + 1] = ipat(i)[15:8];
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R10 reset cs_n", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R10 reset sck", int'(spi_sck), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R11 idle after reset", int'(busy), 0);

        for (int v = 0; v < NVEC; v++) begin
            int off, cnt, rb, seg0, fr0, st0, wr0, pop0, segs;
            off  = int'(VECS[v].off);
            cnt  = int'(VECS[v].cnt);
            rb   = rd_n; seg0 = wseg; fr0 = frames; st0 = stat_reads;
            wr0  = wren_cnt; pop0 = wr_idx;
            run_req(VECS[v].wr, off, cnt, v, e);
            repeat (2) @(negedge clk);
            chk(e == VECS[v].exp_err, "R9 error flag", int'(e), int'(VECS[v].exp_err));
            if (VECS[v].exp_err) begin
                chk(frames == fr0, "R9 no frame on reject", frames - fr0, 0);
            end else if (VECS[v].wr) begin
                segs = ((2 * (off + cnt) - 1) / PAGE) - ((2 * off) / PAGE) + 1;
                chk(wseg - seg0 == segs, "R8 write segments", wseg - seg0, segs);
                chk(wren_cnt - wr0 == segs, "R7 write enables", wren_cnt - wr0, segs);
                chk(wr_idx - pop0 == cnt, "R6 words taken", wr_idx - pop0, cnt);
                if (off + cnt > 128)
                    chk(last_op == 8'h0A, "R4 write opcode", int'(last_op), 'h0A);
                for (int k = 0; k < cnt; k++) shadow[off + k] = wval(off + k, v);
            end else begin
                chk(rd_n - rb == cnt, "R5 word count", rd_n - rb, cnt);
                for (int k = 0; k < cnt; k++)
                    chk(rd_buf[(rb + k) % 64] == shadow[off + k], "R5 read data",
                        int'(rd_buf[(rb + k) % 64]), int'(shadow[off + k]));
                chk(last_addr == (2 * off) % 512, "R3 byte address", last_addr, (2 * off) % 512);
                chk(last_op == ((off >= 128) ? 8'h0B : 8'h03), "R4 read opcode",
                    int'(last_op), (off >= 128) ? 'h0B : 'h03);
                if (v == 1)
                    chk(stat_reads - st0 == 3, "R1 polls after write", stat_reads - st0, 3);
            end
        end

        begin
            int st0, seg0;
            st0 = stat_reads; seg0 = wseg;
            force_busy = 1;
            run_req(1'b1, 10, 1, 99, e);
            chk(e == 1'b1, "R2 timeout error", int'(e), 1);
            chk(stat_reads - st0 == TRIES, "R2 poll attempts", stat_reads - st0, TRIES);
            chk(wseg == seg0, "R2 no write", wseg - seg0, 0);
            @(negedge clk);
            chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R10 terminated", int'(spi_cs_n), 1);
            force_busy = 0;
            st0 = rd_n;
            run_req(1'b0, 10, 1, 0, e);
            repeat (2) @(negedge clk);
            chk(!e && rd_buf[st0 % 64] == shadow[10], "R2 data unchanged",
                int'(rd_buf[st0 % 64]), int'(shadow[10]));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule